// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block holds the processor's 32-bit status word and decides, once per clock, whether the core continues, enters an exception handler, or returns from one. Seven sources can raise an exception: reset request, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction and supervisor call. The two interrupt inputs are levels, and each has a mask bit in the status word. Every source except the reset request waits for the instruction-boundary strobe.

When an exception is taken, the block does all of its work in one clock edge. It switches the mode field and sets the interrupt masks. It tells the mode-banked register file to store the return address in the new mode's link register and to store the old status word in the new mode's saved-status slot. It also loads the program counter with the exception's vector. When a return is commanded, the register file supplies the saved status of the active mode. The block restores that word and reloads the program counter at the same edge. The block stores no general registers and fetches no instructions.

Top module: `trap_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `stat_word` is 0x000000D3 and `pc_load`, `lr_we` and `sav_we` are 0.
- R2: A high `req_reset` at a clock edge is taken at that edge whatever `insn_done` is. After that edge, `pc_value` is the vector base plus 0x00 and `stat_word` is exactly 0x000000D3: flags cleared, both masks set, 32-bit state, supervisor mode 0x13. No link or saved-status write is issued.
- R3: Every other exception is taken only at an edge where `insn_done` is 1. Its outputs appear in the cycle that follows that edge.
- R4: When several sources qualify at one edge, the highest-priority source wins. The order from highest to lowest is reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, supervisor call. The losing pulse requests are dropped.
- R5: Each source has its own vector offset and new mode (mode field in bits 4:0). Undefined instruction uses 0x04 and mode 0x1B. Supervisor call uses 0x08 and mode 0x13. Prefetch abort uses 0x0C and mode 0x17. Data abort uses 0x10 and mode 0x17. Normal interrupt uses 0x18 and mode 0x12. Fast interrupt uses 0x1C and mode 0x11. With `HIGH_VEC` at its default of 0, the vector base is 0.
- R6: On a non-reset entry, `lr_we` writes `next_pc` into the new mode's link register, and `sav_we` writes the status word from before the entry into the new mode's saved-status slot. Both `lr_mode` and `sav_mode` carry the new mode.
- R7: On entry, the status word changes as follows. Bit 5 (state) is cleared. Bit 7 (normal-interrupt mask) is set. Bit 6 (fast-interrupt mask) is set for a fast interrupt and otherwise left unchanged. The mode changes. The flags in bits 31:28 and all other bits are kept.
- R8: `irq_lvl` is ignored while status bit 7 is 1, and `fiq_lvl` is ignored while status bit 6 is 1. Either level held high while masked never causes an entry.
- R9: `ret_cmd` at an edge loads `pc_value` with `ret_addr` and `stat_word` with `sav_rd` at that same edge, and issues no link or saved-status write. It takes precedence over every source except the reset request. Pulse requests present at that edge are dropped.
- R10: `pc_load`, `lr_we` and `sav_we` are one-cycle strobes for each event taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_reset | input | 1 | Reset exception request, taken immediately |
| req_undef | input | 1 | Undefined-instruction request |
| req_svcall | input | 1 | Supervisor-call request |
| req_pabort | input | 1 | Prefetch-abort request |
| req_dabort | input | 1 | Data-abort request |
| irq_lvl | input | 1 | Normal interrupt, level-sensitive |
| fiq_lvl | input | 1 | Fast interrupt, level-sensitive |
| insn_done | input | 1 | Instruction-boundary strobe |
| next_pc | input | ADDR_W | Address of the next instruction, used as the return address |
| ret_cmd | input | 1 | Exception-return command |
| ret_addr | input | ADDR_W | Program counter to resume at on return |
| sav_rd | input | 32 | Saved status of the active mode, supplied by the register file |
| pc_load | output | 1 | Program-counter load strobe |
| pc_value | output | ADDR_W | New program counter |
| lr_we | output | 1 | Link-register write strobe |
| lr_mode | output | 5 | Mode whose link register is written |
| lr_value | output | ADDR_W | Return address to write |
| sav_we | output | 1 | Saved-status write strobe |
| sav_mode | output | 5 | Mode whose saved-status slot is written |
| sav_value | output | 32 | Status word before the entry |
| stat_word | output | 32 | Current status word |

## Verification
Every result comes from one register stage. The strobes, vector, link value, saved value and new status word for an edge that takes an event are all visible in the cycle right after that edge, and the strobes drop again one cycle later. The driver changes inputs on a falling edge and pushes the expected record into a queue at that moment. The monitor pops and compares on the next falling edge, which is half a period after the deciding rising edge, so each comparison lands exactly on the due cycle. A `pc_load` with an empty queue, or any strobe still high one cycle after an event, counts as a failure. The quiet windows, where a masked level or a missing boundary must not cause an entry, are checked cycle by cycle at the ports.

// File: rtl/trap_pkg.sv
package trap_pkg;
   localparam int STAT_W    = 32;
   localparam int MODE_W    = 5;
   localparam int BIT_STATE = 5;
   localparam int BIT_FMASK = 6;
   localparam int BIT_NMASK = 7;
   localparam int NUM_KINDS = 7;
   localparam int KIND_W    = $clog2(NUM_KINDS);

   // index order is the priority order, highest first
   typedef enum logic [KIND_W-1:0] {
      K_RESET  = 3'd0,
      K_DABT   = 3'd1,
      K_FAST   = 3'd2,
      K_NORM   = 3'd3,
      K_PABT   = 3'd4,
      K_UNDEF  = 3'd5,
      K_SVCALL = 3'd6
   } kind_e;

   localparam logic [MODE_W-1:0] M_USER  = 5'h10;
   localparam logic [MODE_W-1:0] M_FAST  = 5'h11;
   localparam logic [MODE_W-1:0] M_NORM  = 5'h12;
   localparam logic [MODE_W-1:0] M_SUPV  = 5'h13;
   localparam logic [MODE_W-1:0] M_ABORT = 5'h17;
   localparam logic [MODE_W-1:0] M_UNDEF = 5'h1B;

   localparam logic [STAT_W-1:0] RESET_WORD = 32'h0000_00D3;

   function automatic logic [MODE_W-1:0] kind_mode(kind_e k);
      case (k)
         K_RESET:  return M_SUPV;
         K_DABT:   return M_ABORT;
         K_FAST:   return M_FAST;
         K_NORM:   return M_NORM;
         K_PABT:   return M_ABORT;
         K_UNDEF:  return M_UNDEF;
         K_SVCALL: return M_SUPV;
         default:  return M_SUPV;
      endcase
   endfunction

   function automatic logic [7:0] kind_offset(kind_e k);
      case (k)
         K_RESET:  return 8'h00;
         K_UNDEF:  return 8'h04;
         K_SVCALL: return 8'h08;
         K_PABT:   return 8'h0C;
         K_DABT:   return 8'h10;
         K_NORM:   return 8'h18;
         K_FAST:   return 8'h1C;
         default:  return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
   parameter int N = 7
) (
   input  logic [N-1:0]         req,
   output logic                 any,
   output logic [$clog2(N)-1:0] idx
);
   localparam int IW = $clog2(N);

   if (N < 2) begin : g_bad_n
      $error("trap_arbiter: N must be at least 2");
   end

   logic [N-1:0] higher;
   logic [N-1:0] grant;

   // bit 0 has top priority; each bit is blocked by any lower index
   for (genvar g = 0; g < N; g++) begin : g_chain
      if (g == 0) begin : g_top
         assign higher[g] = 1'b0;
      end else begin : g_rest
         assign higher[g] = |req[g-1:0];
      end
      assign grant[g] = req[g] & ~higher[g];
   end

   assign any = |req;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/trap_vector_map.sv
module trap_vector_map
   import trap_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter bit HIGH_VEC = 1'b0
) (
   input  kind_e               kind,
   output logic [ADDR_W-1:0]   vec,
   output logic [MODE_W-1:0]   mode
);
   logic [ADDR_W-1:0] base;

   if (HIGH_VEC) begin : g_high
      if (ADDR_W < 17) begin : g_bad_w
         $error("trap_vector_map: high vectors need ADDR_W above 16");
      end
      assign base = {{(ADDR_W-16){1'b1}}, 16'h0000};
   end else begin : g_low
      assign base = '0;
   end

   assign vec  = base | ADDR_W'(kind_offset(kind));
   assign mode = kind_mode(kind);
endmodule

// File: rtl/trap_status_unit.sv
module trap_status_unit
   import trap_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              do_reset,
   input  logic              do_ret,
   input  logic              do_enter,
   input  kind_e             kind,
   input  logic [MODE_W-1:0] new_mode,
   input  logic [STAT_W-1:0] restore,
   output logic [STAT_W-1:0] stat_q
);
   logic [STAT_W-1:0] stat_d;

   always_comb begin
      stat_d = stat_q;
      if (do_reset) begin
         stat_d = RESET_WORD;
      end else if (do_ret) begin
         stat_d = restore;
      end else if (do_enter) begin
         stat_d[BIT_STATE]    = 1'b0;
         stat_d[BIT_NMASK]    = 1'b1;
         if (kind == K_FAST) stat_d[BIT_FMASK] = 1'b1;
         stat_d[MODE_W-1:0]   = new_mode;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= RESET_WORD;
      else        stat_q <= stat_d;
   end
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
   import trap_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter bit HIGH_VEC = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_reset,
   input  logic              req_undef,
   input  logic              req_svcall,
   input  logic              req_pabort,
   input  logic              req_dabort,
   input  logic              irq_lvl,
   input  logic              fiq_lvl,
   input  logic              insn_done,
   input  logic [ADDR_W-1:0] next_pc,
   input  logic              ret_cmd,
   input  logic [ADDR_W-1:0] ret_addr,
   input  logic [31:0]       sav_rd,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_value,
   output logic              lr_we,
   output logic [4:0]        lr_mode,
   output logic [ADDR_W-1:0] lr_value,
   output logic              sav_we,
   output logic [4:0]        sav_mode,
   output logic [31:0]       sav_value,
   output logic [31:0]       stat_word
);
   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr
      $error("trap_sequencer: ADDR_W must lie in 8..64");
   end

   logic [NUM_KINDS-1:0] req_vec;
   logic                 win_any;
   logic [KIND_W-1:0]    win_idx;
   kind_e                win_kind;
   logic [ADDR_W-1:0]    win_vec;
   logic [MODE_W-1:0]    win_mode;
   logic [STAT_W-1:0]    stat_q;
   logic                 take_reset, take_ret, take_enter;

   // qualify sources: reset is immediate, the rest wait for a boundary
   always_comb begin
      req_vec           = '0;
      req_vec[K_RESET]  = req_reset;
      req_vec[K_DABT]   = insn_done & req_dabort;
      req_vec[K_FAST]   = insn_done & fiq_lvl & ~stat_q[BIT_FMASK];
      req_vec[K_NORM]   = insn_done & irq_lvl & ~stat_q[BIT_NMASK];
      req_vec[K_PABT]   = insn_done & req_pabort;
      req_vec[K_UNDEF]  = insn_done & req_undef;
      req_vec[K_SVCALL] = insn_done & req_svcall;
   end

   trap_arbiter #(.N(NUM_KINDS)) u_arb (
      .req (req_vec),
      .any (win_any),
      .idx (win_idx)
   );

   assign win_kind = kind_e'(win_idx);

   trap_vector_map #(.ADDR_W(ADDR_W), .HIGH_VEC(HIGH_VEC)) u_map (
      .kind (win_kind),
      .vec  (win_vec),
      .mode (win_mode)
   );

   assign take_reset = req_reset;
   assign take_ret   = ret_cmd & ~req_reset;
   assign take_enter = win_any & ~req_reset & ~ret_cmd;

   trap_status_unit u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_reset (take_reset),
      .do_ret   (take_ret),
      .do_enter (take_enter),
      .kind     (win_kind),
      .new_mode (win_mode),
      .restore  (sav_rd),
      .stat_q   (stat_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_load   <= 1'b0;
         pc_value  <= '0;
         lr_we     <= 1'b0;
         lr_mode   <= '0;
         lr_value  <= '0;
         sav_we    <= 1'b0;
         sav_mode  <= '0;
         sav_value <= '0;
      end else begin
         pc_load  <= take_reset | take_ret | take_enter;
         pc_value <= take_ret ? ret_addr : win_vec;
         lr_we    <= take_enter;
         sav_we   <= take_enter;
         if (take_enter) begin
            lr_mode   <= win_mode;
            lr_value  <= next_pc;
            sav_mode  <= win_mode;
            sav_value <= stat_q;
         end
      end
   end

   assign stat_word = stat_q;
endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_reset,
   input logic              insn_done,
   input logic              ret_cmd,
   input logic [ADDR_W-1:0] ret_addr,
   input logic [31:0]       sav_rd,
   input logic              pc_load,
   input logic [ADDR_W-1:0] pc_value,
   input logic              lr_we,
   input logic [4:0]        lr_mode,
   input logic              sav_we,
   input logic [4:0]        sav_mode,
   input logic [31:0]       sav_value,
   input logic [31:0]       stat_word
);
   assert_entry_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lr_we |-> (!stat_word[5] && stat_word[7]));

   assert_fast_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lr_we && lr_mode == 5'h11) |-> stat_word[6]);

   assert_saved_old_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sav_we |-> (lr_we && sav_value == $past(stat_word) && sav_mode == stat_word[4:0]));

   assert_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lr_we |-> $past(insn_done));

   assert_norm_unmasked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lr_we && lr_mode == 5'h12) |-> !$past(stat_word[7]));

   assert_reset_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(req_reset)) |->
         (pc_load && !lr_we && pc_value[7:0] == 8'h00 && stat_word == 32'h0000_00D3));

   assert_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ret_cmd) && !$past(req_reset)) |->
         (pc_load && !lr_we && pc_value == $past(ret_addr) && stat_word == $past(sav_rd)));
endmodule

bind trap_sequencer trap_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_reset (req_reset),
   .insn_done (insn_done),
   .ret_cmd   (ret_cmd),
   .ret_addr  (ret_addr),
   .sav_rd    (sav_rd),
   .pc_load   (pc_load),
   .pc_value  (pc_value),
   .lr_we     (lr_we),
   .lr_mode   (lr_mode),
   .sav_we    (sav_we),
   .sav_mode  (sav_mode),
   .sav_value (sav_value),
   .stat_word (stat_word)
);

// File: tb/trap_sequencer_test.sv
module trap_sequencer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_reset = 0, req_undef = 0, req_svcall = 0, req_pabort = 0, req_dabort = 0;
   logic        irq_lvl = 0, fiq_lvl = 0, insn_done = 0, ret_cmd = 0;
   logic [31:0] next_pc = 0, ret_addr = 0, sav_rd = 0;
   logic        pc_load, lr_we, sav_we;
   logic [31:0] pc_value, lr_value, sav_value, stat_word;
   logic [4:0]  lr_mode, sav_mode;

   int n_checks = 0;
   int n_err    = 0;
   bit done     = 0;

   typedef struct {
      logic [31:0] pc;
      logic        lw;
      logic [4:0]  lm;
      logic [31:0] lv;
      logic        sw;
      logic [4:0]  sm;
      logic [31:0] sv;
      logic [31:0] st;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   logic [31:0] m_st;

   always #2 clk = ~clk;

   trap_sequencer uut (
      .clk(clk), .rst_n(rst_n), .req_reset(req_reset), .req_undef(req_undef),
      .req_svcall(req_svcall), .req_pabort(req_pabort), .req_dabort(req_dabort),
      .irq_lvl(irq_lvl), .fiq_lvl(fiq_lvl), .insn_done(insn_done), .next_pc(next_pc),
      .ret_cmd(ret_cmd), .ret_addr(ret_addr), .sav_rd(sav_rd),
      .pc_load(pc_load), .pc_value(pc_value), .lr_we(lr_we), .lr_mode(lr_mode),
      .lr_value(lr_value), .sav_we(sav_we), .sav_mode(sav_mode), .sav_value(sav_value),
      .stat_word(stat_word)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // expected entry: caller gives vector, mode, fast flag from the requirements
   task automatic push_entry(string tag, logic [31:0] vec, logic [4:0] mode, bit fast, logic [31:0] npc);
      exp_t e;
      logic [31:0] s;
      s = m_st;
      s[5] = 1'b0;
      s[7] = 1'b1;
      if (fast) s[6] = 1'b1;
      s[4:0] = mode;
      e.pc = vec; e.lw = 1; e.lm = mode; e.lv = npc;
      e.sw = 1; e.sm = mode; e.sv = m_st; e.st = s;
      m_st = s;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic push_plain(string tag, logic [31:0] pc, logic [31:0] st);
      exp_t e;
      e.pc = pc; e.lw = 0; e.lm = 0; e.lv = 0; e.sw = 0; e.sm = 0; e.sv = 0; e.st = st;
      m_st = st;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // drive for one rising edge, then release pulses and confirm strobes drop (R10)
   task automatic finish_event();
      @(negedge clk);
      req_reset = 0; req_undef = 0; req_svcall = 0; req_pabort = 0; req_dabort = 0;
      ret_cmd = 0; insn_done = 0;
      @(negedge clk);
      check("R10 strobes one cycle", {29'd0, pc_load, lr_we, sav_we}, 32'd0);
   endtask

   task automatic do_return(logic [31:0] addr, logic [31:0] saved);
      @(negedge clk);
      ret_cmd = 1; ret_addr = addr; sav_rd = saved;
      push_plain("R9 return", addr, saved);
      finish_event();
   endtask

   task automatic quiet(string req, int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check(req, {31'd0, pc_load}, 32'd0);
      end
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && pc_load) begin
            if (exp_q.size() == 0) begin
               check("R3 unexpected pc_load", 32'd1, 32'd0);
            end else begin
               exp_t  e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check({t, " pc"}, pc_value, e.pc);
               check({t, " status"}, stat_word, e.st);
               check({t, " R6 lr_we"}, {31'd0, lr_we}, {31'd0, e.lw});
               check({t, " R6 sav_we"}, {31'd0, sav_we}, {31'd0, e.sw});
               if (e.lw) begin
                  check({t, " R6 lr_mode"}, {27'd0, lr_mode}, {27'd0, e.lm});
                  check({t, " R6 lr_value"}, lr_value, e.lv);
               end
               if (e.sw) begin
                  check({t, " R6 sav_mode"}, {27'd0, sav_mode}, {27'd0, e.sm});
                  check({t, " R6 sav_value"}, sav_value, e.sv);
               end
            end
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

   initial begin
      m_st = 32'h0000_00D3;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 status in reset", stat_word, 32'h0000_00D3);
      rst_n = 1;
      @(negedge clk);
      check("R1 status after reset", stat_word, 32'h0000_00D3);
      check("R1 strobes low", {29'd0, pc_load, lr_we, sav_we}, 32'd0);

      // R9: return into user mode, thumb state, flags set
      do_return(32'h0000_1000, 32'hF000_0030);

      // R3: level interrupt without a boundary is not taken
      @(negedge clk);
      irq_lvl = 1;
      quiet("R3 no boundary", 3);
      @(negedge clk);
      insn_done = 1; next_pc = 32'h0000_1004;
      push_entry("R5 R7 normal irq", 32'h18, 5'h12, 0, 32'h0000_1004);
      @(negedge clk);
      // R8: level still high, now masked by bit 7
      quiet("R8 normal masked", 3);
      irq_lvl = 0; insn_done = 0;
      @(negedge clk);
      check("R10 strobes low", {29'd0, pc_load, lr_we, sav_we}, 32'd0);

      // R4: fast beats normal and prefetch abort
      do_return(32'h0000_2000, 32'h0000_0010);
      @(negedge clk);
      fiq_lvl = 1; irq_lvl = 1; req_pabort = 1; insn_done = 1; next_pc = 32'h0000_2008;
      push_entry("R4 fast first", 32'h1C, 5'h11, 1, 32'h0000_2008);
      finish_event();
      irq_lvl = 0;

      // R8: fast level held while masked; data abort still taken, F kept
      @(negedge clk);
      req_dabort = 1; insn_done = 1; next_pc = 32'h0000_3000;
      push_entry("R5 R7 abort in fast mode", 32'h10, 5'h17, 0, 32'h0000_3000);
      finish_event();
      quiet("R8 fast masked", 2);
      fiq_lvl = 0;

      // R4: data abort beats fast interrupt
      do_return(32'h0000_4000, 32'h6000_0010);
      @(negedge clk);
      req_dabort = 1; fiq_lvl = 1; insn_done = 1; next_pc = 32'h0000_4004;
      push_entry("R4 data abort first", 32'h10, 5'h17, 0, 32'h0000_4004);
      finish_event();
      fiq_lvl = 0;

      // R4/R5: undefined beats supervisor call
      do_return(32'h0000_5000, 32'h0000_0010);
      @(negedge clk);
      req_undef = 1; req_svcall = 1; insn_done = 1; next_pc = 32'h0000_5004;
      push_entry("R4 R5 undefined", 32'h04, 5'h1B, 0, 32'h0000_5004);
      finish_event();

      // R5: supervisor call alone
      do_return(32'h0000_6000, 32'h0000_0010);
      @(negedge clk);
      req_svcall = 1; insn_done = 1; next_pc = 32'h0000_6004;
      push_entry("R5 supervisor call", 32'h08, 5'h13, 0, 32'h0000_6004);
      finish_event();

      // R5: prefetch abort alone
      do_return(32'h0000_7000, 32'h0000_0010);
      @(negedge clk);
      req_pabort = 1; insn_done = 1; next_pc = 32'h0000_7004;
      push_entry("R5 prefetch abort", 32'h0C, 5'h17, 0, 32'h0000_7004);
      finish_event();

      // R8: user mode with normal mask set ignores irq, takes fiq
      do_return(32'h0000_8000, 32'h0000_0090);
      @(negedge clk);
      irq_lvl = 1; insn_done = 1;
      quiet("R8 irq ignored when bit7 set", 3);
      @(negedge clk);
      fiq_lvl = 1; next_pc = 32'h0000_8010;
      push_entry("R4 R8 fast while normal masked", 32'h1C, 5'h11, 1, 32'h0000_8010);
      finish_event();
      irq_lvl = 0; fiq_lvl = 0;

      // R9: return wins over a supervisor call at the same edge
      @(negedge clk);
      ret_cmd = 1; ret_addr = 32'h0000_9000; sav_rd = 32'h3000_0010;
      req_svcall = 1; insn_done = 1;
      push_plain("R9 return over call", 32'h0000_9000, 32'h3000_0010);
      finish_event();
      quiet("R9 call dropped", 2);

      // R2: reset request mid-instruction, with other sources present
      @(negedge clk);
      req_reset = 1; req_dabort = 1; irq_lvl = 1; insn_done = 0;
      push_plain("R2 reset request", 32'h0000_0000, 32'h0000_00D3);
      finish_event();
      irq_lvl = 0;
      quiet("R2 no follow-up", 2);

      @(negedge clk);
      check("R3 queue drained", exp_q.size(), 32'd0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule